// File: doc/BRIEF.md
# Card Data FIFO Engine

This block moves payload between a host register window and a byte-wide card data port through a 16-word by 32-bit FIFO. A transfer starts when the host writes the control register with the go bit set. That write loads a byte down-counter from the length register. In the card-to-host direction the engine collects card bytes into little-endian words and pushes them into the FIFO for the host to read. In the host-to-card direction it pops words that the host has written and sends them to the card one byte at a time, lowest byte first.

The counter works in bytes, so a transfer need not fill its last word. The status register reports an end-of-data flag. It also reports a FIFO level flag set for the active direction only. After each host read of the FIFO, the card-to-host direction pauses until the host polls the status register or the word-count register. A host driver therefore never sees fresh data land while it is still emptying the FIFO.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset the length, control, byte count and status registers read 0, `card_rx_ready` is 0 and `card_tx_valid` is 0.
- R2: In the card-to-host direction (control bit 1 = 1), the byte accepted first lands in bits 7:0 of a FIFO word and the following bytes fill bits 15:8, 23:16 and 31:24. When the counter reaches zero with a word partly filled, that word is pushed with its unfilled upper lanes at zero. Each accepted byte lowers the counter by one.
- R3: In the host-to-card direction (control bit 1 = 0), each word is sent bits 7:0 first. Each byte sent lowers the counter by one, and the engine stops sending when the counter reaches zero, even partway through a word.
- R4: The length register (select 0) keeps only bits 15:0 of a write, and the control register (select 1) keeps only bits 7:0. A control write with bit 0 set loads the counter from the length register and starts the engine.
- R5: While the engine runs with the counter at zero, status bits 8 and 10 become set, and they clear at the next start. Control bit 0 clears itself once the counter is zero and the FIFO is empty.
- R6: While the engine runs and has bytes or words left, the status register reports only one flag set, selected by direction. In the card-to-host direction the flags are active (13), half-full (15, occupancy at least 8), full (17, occupancy 16), empty (19) and data-available (21). In the host-to-card direction the flags are active (12), half-empty (14, occupancy at most 8), full (16), empty (18) and data-available (20). In every other state these bits read 0.
- R7: A host FIFO read that removes a word stops the engine from accepting further card bytes. A read of the status register (select 2) or the word-count register (select 3) lifts the pause. A read of any other register does not.
- R8: The word-count register (select 3) reads the remaining byte count rounded up to words, (count + 3) >> 2.
- R9: A host read of the FIFO window (select 4) while the FIFO is empty returns 0 and changes nothing. A host write to the window while the counter is zero is dropped.
- R10: A push into a full FIFO is dropped. In the card-to-host direction `card_rx_ready` stays low while the FIFO holds 16 words.
- R11: Host window reads remove words only in the card-to-host direction and return 0 otherwise. Host window writes add words only in the host-to-card direction.
- R12: The byte-count register (select 5) reads the remaining byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Register select: 0 length, 1 control, 2 status, 3 word count, 4 FIFO window, 5 byte count |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; its side effects take place at the clock edge |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register, valid in the same cycle |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte offered by the card |
| card_rx_ready | output | 1 | Engine accepts the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte offered to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |

## Verification
A read pointer or occupancy count that drifts shows up on the next window read as a word that is wrong or out of order. It also shows up as level flags that disagree with the number of words the bench has moved, so it becomes visible as soon as the host next polls. A counter that is off by one shows up at the end of a transfer. Either one byte too many or too few crosses the card port, or the go bit fails to clear within a cycle of the FIFO draining. A pause flag that is never set or never cleared shows up within a few cycles as a byte count that keeps falling when it should hold, or that holds after a poll.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int CTRL_W      = 8;
    localparam int SEL_W       = 3;
    localparam int DEF_DEPTH   = 16;
    localparam int DEF_LEN_W   = 16;

    typedef enum logic [SEL_W-1:0] {
        SEL_LEN   = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_WCNT  = 3'd3,
        SEL_WIN   = 3'd4,
        SEL_BCNT  = 3'd5
    } reg_sel_e;

    localparam int CTRL_GO  = 0;
    localparam int CTRL_DIR = 1;

    localparam int ST_DEND   = 8;
    localparam int ST_BEND   = 10;
    localparam int ST_TXACT  = 12;
    localparam int ST_RXACT  = 13;
    localparam int ST_TXHE   = 14;
    localparam int ST_RXHF   = 15;
    localparam int ST_TXFULL = 16;
    localparam int ST_RXFULL = 17;
    localparam int ST_TXEMP  = 18;
    localparam int ST_RXEMP  = 19;
    localparam int ST_TXAV   = 20;
    localparam int ST_RXAV   = 21;

    typedef struct packed {
        logic active;
        logic empty;
        logic avail;
        logic full;
        logic low_half;
        logic high_half;
    } level_t;

    function automatic level_t fifo_level(input logic live, input int unsigned occ,
                                          input int unsigned depth);
        level_t lv;
        lv.active    = live;
        lv.empty     = live && (occ == 0);
        lv.avail     = live && (occ != 0);
        lv.full      = live && (occ == depth);
        lv.low_half  = live && (occ <= depth / 2);
        lv.high_half = live && (occ >= depth / 2);
        return lv;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic dend, input logic to_host,
                                                      input level_t lv);
        logic [WORD_W-1:0] s;
        s = '0;
        s[ST_DEND] = dend;
        s[ST_BEND] = dend;
        if (to_host) begin
            s[ST_RXACT]  = lv.active;
            s[ST_RXHF]   = lv.high_half;
            s[ST_RXFULL] = lv.full;
            s[ST_RXEMP]  = lv.empty;
            s[ST_RXAV]   = lv.avail;
        end else begin
            s[ST_TXACT]  = lv.active;
            s[ST_TXHE]   = lv.low_half;
            s[ST_TXFULL] = lv.full;
            s[ST_TXEMP]  = lv.empty;
            s[ST_TXAV]   = lv.avail;
        end
        return s;
    endfunction

endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    occ
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_idx;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (occ != CW'(DEPTH));
    assign do_pop  = pop && (occ != '0);
    assign wr_idx  = rd_ptr + occ[PW-1:0];
    assign head    = (occ != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_idx] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_pop) begin
                rd_ptr <= rd_ptr + PW'(1);
            end
            occ <= occ + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/cfe_rx_pack.sv
module cfe_rx_pack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int LW = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              enable,
    input  logic              last_byte,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    output logic              byte_take,
    output logic              word_push,
    output logic [WORD_W-1:0] word_data
);

    logic [LW-1:0]     lane_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;

    assign byte_ready = enable;
    assign byte_take  = enable && byte_valid;

    always_comb begin
        merged = acc_q;
        merged[lane_q*BYTE_W +: BYTE_W] = byte_data;
    end

    assign word_push = byte_take && ((lane_q == LW'(LANES - 1)) || last_byte);
    assign word_data = merged;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            lane_q <= '0;
            acc_q  <= '0;
        end else if (byte_take) begin
            if (word_push) begin
                lane_q <= '0;
                acc_q  <= '0;
            end else begin
                lane_q <= lane_q + LW'(1);
                acc_q  <= merged;
            end
        end
    end

endmodule

// File: rtl/cfe_tx_unpack.sv
module cfe_tx_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int LC = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              enable,
    input  logic              word_avail,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_pop,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_ready,
    output logic              byte_take
);

    logic [WORD_W-1:0] sr_q;
    logic [LC-1:0]     left_q;

    assign word_pop   = enable && (left_q == '0) && word_avail;
    assign byte_valid = enable && (left_q != '0);
    assign byte_take  = byte_valid && byte_ready;
    assign byte_data  = sr_q[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (word_pop) begin
            sr_q   <= word_in;
            left_q <= LC'(LANES);
        end else if (byte_take) begin
            sr_q   <= sr_q >> BYTE_W;
            left_q <= left_q - LC'(1);
        end
    end

endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int LEN_W = DEF_LEN_W,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              card_rx_valid,
    input  logic [BYTE_W-1:0] card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [BYTE_W-1:0] card_tx_data,
    input  logic              card_tx_ready
);

    reg_sel_e          sel;
    logic [LEN_W-1:0]  len_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              dend_q;
    logic              hold_q;

    logic              run, to_host, cnt_zero;
    logic              ctrl_wr, start;
    logic              host_pop, host_push, poll_rd;
    logic              rx_en, tx_en;
    logic              rx_take, rx_push, tx_take, tx_pop;
    logic [WORD_W-1:0] rx_word;
    logic              f_push, f_pop;
    logic [WORD_W-1:0] f_push_data, f_head;
    logic [CW-1:0]     occ;
    logic              fifo_empty, fifo_full, live;
    level_t            level;
    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] words_left;

    assign sel       = reg_sel_e'(host_sel);
    assign run       = ctrl_q[CTRL_GO];
    assign to_host   = ctrl_q[CTRL_DIR];
    assign cnt_zero  = (cnt_q == '0);
    assign fifo_empty = (occ == '0);
    assign fifo_full  = (occ == CW'(DEPTH));

    assign ctrl_wr   = host_wr && (sel == SEL_CTRL);
    assign start     = ctrl_wr && host_wdata[CTRL_GO];
    assign host_pop  = host_rd && (sel == SEL_WIN) && to_host && !fifo_empty;
    assign host_push = host_wr && (sel == SEL_WIN) && !to_host && !cnt_zero;
    assign poll_rd   = host_rd && ((sel == SEL_STAT) || (sel == SEL_WCNT));

    assign rx_en = run && to_host && !cnt_zero && !hold_q && !fifo_full;
    assign tx_en = run && !to_host && !cnt_zero;

    cfe_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .enable     (rx_en),
        .last_byte  (cnt_q == LEN_W'(1)),
        .byte_valid (card_rx_valid),
        .byte_data  (card_rx_data),
        .byte_ready (card_rx_ready),
        .byte_take  (rx_take),
        .word_push  (rx_push),
        .word_data  (rx_word)
    );

    cfe_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .enable     (tx_en),
        .word_avail (!fifo_empty),
        .word_in    (f_head),
        .word_pop   (tx_pop),
        .byte_valid (card_tx_valid),
        .byte_data  (card_tx_data),
        .byte_ready (card_tx_ready),
        .byte_take  (tx_take)
    );

    assign f_push      = to_host ? rx_push : host_push;
    assign f_push_data = to_host ? rx_word : host_wdata;
    assign f_pop       = to_host ? host_pop : tx_pop;

    cfe_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (f_push),
        .push_data (f_push_data),
        .pop       (f_pop),
        .head      (f_head),
        .occ       (occ)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            ctrl_q <= '0;
            cnt_q  <= '0;
            dend_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (host_wr && (sel == SEL_LEN)) begin
                len_q <= host_wdata[LEN_W-1:0];
            end

            if (ctrl_wr) begin
                ctrl_q <= host_wdata[CTRL_W-1:0];
            end else if (run && cnt_zero && fifo_empty) begin
                ctrl_q[CTRL_GO] <= 1'b0;
            end

            if (start) begin
                cnt_q <= len_q;
            end else if (rx_take || tx_take) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end

            if (start) begin
                dend_q <= 1'b0;
            end else if (run && cnt_zero) begin
                dend_q <= 1'b1;
            end

            if (host_pop) begin
                hold_q <= 1'b1;
            end else if (poll_rd) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign live       = run && !(cnt_zero && fifo_empty);
    assign level      = fifo_level(live, int'(occ), DEPTH);
    assign status_w   = status_word(dend_q, to_host, level);
    assign words_left = (WORD_W'(cnt_q) + WORD_W'(3)) >> 2;

    always_comb begin
        unique case (sel)
            SEL_LEN:  host_rdata = WORD_W'(len_q);
            SEL_CTRL: host_rdata = WORD_W'(ctrl_q);
            SEL_STAT: host_rdata = status_w;
            SEL_WCNT: host_rdata = words_left;
            SEL_WIN:  host_rdata = host_pop ? f_head : '0;
            SEL_BCNT: host_rdata = WORD_W'(cnt_q);
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/card_fifo_engine_chk.sv
module card_fifo_engine_chk #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    parameter int CW = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CW-1:0]    occ,
    input logic [LEN_W-1:0] cnt_q,
    input logic             hold_q,
    input logic             run,
    input logic             to_host,
    input logic             ctrl_wr,
    input logic             card_rx_valid,
    input logic             card_rx_ready,
    input logic             card_tx_valid,
    input logic             card_tx_ready,
    input logic [31:0]      status_w
);

    localparam logic [31:0] RX_SET = 32'h002A_A000;
    localparam logic [31:0] TX_SET = 32'h0015_5000;

    p_occ_bound_r10: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    p_no_rx_when_full_r10: assert property (@(posedge clk) disable iff (rst)
        card_rx_ready |-> (occ != CW'(DEPTH)));

    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !card_rx_ready);

    p_rx_count_r2: assert property (@(posedge clk) disable iff (rst)
        (card_rx_valid && card_rx_ready && !ctrl_wr) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

    p_tx_count_r3: assert property (@(posedge clk) disable iff (rst)
        (card_tx_valid && card_tx_ready && !ctrl_wr) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

    p_self_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q == '0 && occ == '0 && !ctrl_wr) |=> !run);

    p_one_side_flags_r6: assert property (@(posedge clk) disable iff (rst)
        !(((status_w & RX_SET) != '0) && ((status_w & TX_SET) != '0)));

    p_tx_dir_only_r11: assert property (@(posedge clk) disable iff (rst)
        card_tx_valid |-> !to_host);

endmodule

bind card_fifo_engine card_fifo_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .occ           (occ),
    .cnt_q         (cnt_q),
    .hold_q        (hold_q),
    .run           (run),
    .to_host       (to_host),
    .ctrl_wr       (ctrl_wr),
    .card_rx_valid (card_rx_valid),
    .card_rx_ready (card_rx_ready),
    .card_tx_valid (card_tx_valid),
    .card_tx_ready (card_tx_ready),
    .status_w      (status_w)
);

// File: tb/sim_card_fifo_engine.sv
module sim_card_fifo_engine;

    localparam int CLK_P = 10;
    localparam logic [2:0] S_LEN = 3'd0, S_CTRL = 3'd1, S_STAT = 3'd2,
                           S_WCNT = 3'd3, S_WIN = 3'd4, S_BCNT = 3'd5;
    // {direction (1 = card-to-host), length in bytes, expected words}
    localparam logic [24:0] VEC [6] = '{
        {1'b1, 16'd4, 8'd1}, {1'b1, 16'd7, 8'd2}, {1'b1, 16'd1, 8'd1},
        {1'b0, 16'd8, 8'd2}, {1'b0, 16'd6, 8'd2}, {1'b0, 16'd3, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int rx_total = 0;
    int ntx = 0;
    logic [7:0] tx_log [256];

    always #(CLK_P / 2) clk = ~clk;

    card_fifo_engine u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready)
    );

    assign card_rx_data = 8'(rx_total * 7 + 3);

    always @(posedge clk) begin
        if (card_rx_valid && card_rx_ready) rx_total <= rx_total + 1;
        if (card_tx_valid && card_tx_ready && ntx < 256) begin
            tx_log[ntx] <= card_tx_data;
            ntx <= ntx + 1;
        end
    end

    function automatic logic [7:0] rx_byte(input int idx);
        return 8'(idx * 7 + 3);
    endfunction

    function automatic logic [31:0] rx_word(input int first, input int k, input int len);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++)
            if (4 * k + i < len) w[8*i +: 8] = rx_byte(first + 4 * k + i);
        return w;
    endfunction

    function automatic logic [31:0] tx_word(input int j);
        return 32'h0403_0201 + 32'(j) * 32'h0404_0404;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        host_sel = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_sel = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t0, n0, len, nw, errs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(S_STAT, d); chk(d == 0, "R1 status", d, 0);
        rd(S_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(S_LEN, d);  chk(d == 0, "R1 length", d, 0);
        rd(S_BCNT, d); chk(d == 0, "R12 bytecount", d, 0);
        chk(!card_rx_ready && !card_tx_valid, "R1 card handshakes", {card_rx_ready, card_tx_valid}, 0);

        // Vector table: R2 / R3 / R5 across lengths and directions
        card_tx_ready = 1'b1;
        foreach (VEC[v]) begin
            len = int'(VEC[v][23:8]);
            nw  = int'(VEC[v][7:0]);
            if (VEC[v][24]) begin
                card_rx_valid = 1'b1;
                t0 = rx_total;
                wr(S_LEN, 32'(len)); wr(S_CTRL, 32'h3);
                idle(len + 4);
                for (int k = 0; k < nw; k++) begin
                    rd(S_WIN, d);
                    chk(d == rx_word(t0, k, len), "R2 packed word", d, rx_word(t0, k, len));
                    rd(S_STAT, d);
                end
                card_rx_valid = 1'b0;
            end else begin
                n0 = ntx;
                wr(S_LEN, 32'(len)); wr(S_CTRL, 32'h1);
                for (int k = 0; k < nw; k++) wr(S_WIN, tx_word(k));
                idle(len + 6);
                chk(ntx - n0 == len, "R3 byte total", 32'(ntx - n0), 32'(len));
                errs = 0;
                for (int i = 0; i < len; i++)
                    if (tx_log[n0 + i] != tx_word(i / 4)[8*(i%4) +: 8]) errs++;
                chk(errs == 0, "R3 byte order", 32'(errs), 0);
            end
            rd(S_STAT, d);
            chk(d == 32'h0000_0500, "R5 end flags", d, 32'h0000_0500);
            rd(S_CTRL, d);
            chk(d[0] == 1'b0, "R5 self clear", d, {d[31:1], 1'b0});
        end

        // R8 / R9 / R11 / R6: empty FIFO in card-to-host direction
        card_rx_valid = 1'b0;
        wr(S_LEN, 32'd5); wr(S_CTRL, 32'h3);
        rd(S_WCNT, d); chk(d == 2, "R8 round up", d, 2);
        rd(S_WIN, d);  chk(d == 0, "R9 empty read", d, 0);
        wr(S_WIN, 32'hDEAD_BEEF);
        rd(S_STAT, d);
        chk(d == ((1 << 13) | (1 << 19)), "R11 write ignored / R6 rx empty", d, (1 << 13) | (1 << 19));
        wr(S_CTRL, 32'h0);

        // R10 / R6 / R7 / R8: fill, pause and drain
        card_rx_valid = 1'b1;
        t0 = rx_total;
        wr(S_LEN, 32'd80); wr(S_CTRL, 32'h3);
        idle(80);
        rd(S_BCNT, d); chk(d == 16, "R10 stop when full", d, 16);
        rd(S_STAT, d);
        chk(d == ((1 << 13) | (1 << 15) | (1 << 17) | (1 << 21)), "R6 rx full flags", d,
            (1 << 13) | (1 << 15) | (1 << 17) | (1 << 21));
        rd(S_WCNT, d); chk(d == 4, "R8 word count", d, 4);
        rd(S_WIN, d);  chk(d == rx_word(t0, 0, 80), "R2 first word", d, rx_word(t0, 0, 80));
        idle(6);
        rd(S_BCNT, d); chk(d == 16, "R7 paused after pop", d, 16);
        rd(S_WCNT, d);
        idle(8);
        rd(S_BCNT, d); chk(d == 12, "R7 resumed after poll", d, 12);
        errs = 0;
        for (int k = 1; k < 20; k++) begin
            rd(S_WIN, d);
            if (d != rx_word(t0, k, 80)) errs++;
            rd(S_STAT, d);
            idle(6);
        end
        chk(errs == 0, "R2 drained words", 32'(errs), 0);
        rd(S_CTRL, d); chk(d == 32'h2, "R5 go cleared", d, 32'h2);
        card_rx_valid = 1'b0;

        // R10 / R6 / R11: host-to-card overfill with the card stalled
        card_tx_ready = 1'b0;
        n0 = ntx;
        wr(S_LEN, 32'd68); wr(S_CTRL, 32'h1);
        for (int k = 0; k < 18; k++) wr(S_WIN, tx_word(k));
        rd(S_STAT, d);
        chk(d == ((1 << 12) | (1 << 16) | (1 << 20)), "R6 tx full flags", d, (1 << 12) | (1 << 16) | (1 << 20));
        rd(S_WIN, d); chk(d == 0, "R11 read in tx dir", d, 0);
        card_tx_ready = 1'b1;
        idle(90);
        chk(ntx - n0 == 68, "R10 bytes sent", 32'(ntx - n0), 68);
        errs = 0;
        for (int i = 0; i < 68; i++)
            if (tx_log[n0 + i] != tx_word(i / 4)[8*(i%4) +: 8]) errs++;
        chk(errs == 0, "R10 overflow word dropped", 32'(errs), 0);
        rd(S_CTRL, d); chk(d == 32'h0, "R10 FIFO left empty", d, 0);

        // R9: window write with the counter at zero is dropped
        wr(S_WIN, 32'h1122_3344);
        n0 = ntx;
        wr(S_LEN, 32'd4); wr(S_CTRL, 32'h1);
        idle(8);
        chk(ntx == n0, "R9 write dropped", 32'(ntx - n0), 0);
        rd(S_STAT, d);
        chk(d == ((1 << 12) | (1 << 14) | (1 << 18)), "R9 tx empty / R5 end cleared", d,
            (1 << 12) | (1 << 14) | (1 << 18));
        wr(S_CTRL, 32'h0);

        // R4 / R5: register widths and zero-length start
        wr(S_LEN, 32'h0003_0002);
        rd(S_LEN, d); chk(d == 2, "R4 length width", d, 2);
        wr(S_CTRL, 32'h0000_01F4);
        rd(S_CTRL, d); chk(d == 32'hF4, "R4 control width", d, 32'hF4);
        wr(S_LEN, 32'd0); wr(S_CTRL, 32'h3);
        idle(2);
        rd(S_STAT, d); chk(d == 32'h0000_0500, "R5 zero length end", d, 32'h0000_0500);
        rd(S_CTRL, d); chk(d == 32'h2, "R4 start and self clear", d, 32'h2);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule